// File: doc/BRIEF.md
# Receive Buffer with Per-Character Error Tags

This block sits between a serial receiver's shift register and the host. Each completed character arrives as a one-cycle write strobe carrying the byte and three error flags: parity, framing and break. The block stores the byte and its flags together in a 128-entry first-in first-out queue. The host sees the oldest byte and that byte's own flags. A separate summary flag tells the host whether any flagged character is still queued.

When a character completes while the queue is full, it is dropped. The queue contents are left untouched, and a sticky overrun flag is set. The host clears that flag by reading the status register. A single interrupt request is raised while the line-status interrupt enable is set and there is either a flagged character still queued or a pending overrun. The serial deserializer and the baud generation are outside this block.

Top module: `rx_err_fifo`

## Requirements
- R1: The queue holds exactly 128 characters: 128 pushes into an empty queue with no reads in between are all accepted without setting overrun.
- R2: `data_ready_o` is 0 while the queue is empty and 1 while at least one character is waiting.
- R3: A push in a cycle where the queue holds 128 characters and no read is requested is dropped and sets `overrun_o` on the next edge. If a status read arrives in that same cycle, the set takes priority over the clear.
- R4: A dropped push changes neither the stored characters nor their order; later reads return exactly the bytes accepted earlier.
- R5: `head_data_o` shows the oldest stored byte. A data read strobe removes it when the queue is not empty. A data read on an empty queue has no effect, and `head_data_o` is 0 when the queue is empty.
- R6: `par_err_o`, `frm_err_o` and `brk_err_o` show the flags stored with the character at the head, not those of the latest arrival, and are 0 when the queue is empty.
- R7: `fifo_err_o` is 1 exactly while at least one queued character carries any of its three flags.
- R8: `irq_o` equals `lsi_en_i` AND (`fifo_err_o` OR `overrun_o`), with no added cycle of delay.
- R9: A status read strobe clears `overrun_o` on the next edge, unless a new overrun occurs in that cycle.
- R10: After reset every status output, `head_data_o` and `irq_o` are 0.
- R11: A push and a data read in the same cycle on a full queue are both carried out: the head advances, the new character is stored, and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Character completed by the shift register |
| push_data_i | input | 8 | Received byte |
| push_par_i | input | 1 | Parity error flag of the received byte |
| push_frm_i | input | 1 | Framing error flag of the received byte |
| push_brk_i | input | 1 | Break flag of the received byte |
| data_rd_i | input | 1 | Host read of the holding register (pops the head) |
| stat_rd_i | input | 1 | Host read of the line status register |
| lsi_en_i | input | 1 | Line-status interrupt enable |
| head_data_o | output | 8 | Byte at the read head |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Sticky overrun flag |
| par_err_o | output | 1 | Parity flag of the head character |
| frm_err_o | output | 1 | Framing flag of the head character |
| brk_err_o | output | 1 | Break flag of the head character |
| fifo_err_o | output | 1 | Some queued character carries a flag |
| irq_o | output | 1 | Line-status interrupt request |

## Verification
A push, a data read or a status read takes effect on the clock edge that samples it. The head byte, its flags, `data_ready_o`, `fifo_err_o` and `overrun_o` all change right after that same edge, and `irq_o` follows them combinationally. The bench therefore drives each stimulus at a falling edge and compares every output 2 ns after the next rising edge, against a queue model kept in the bench. The sweep fills the queue, forces overruns with and without a status read in the same cycle, pushes and pops together on a full queue, and drains the queue. It covers a tag pattern that gives each flag alone and in combination, and it runs both with the interrupt enable cleared and with it set.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push_i,
  input  logic [DW-1:0] push_data_i,
  input  logic          push_par_i,
  input  logic          push_frm_i,
  input  logic          push_brk_i,
  input  logic          data_rd_i,
  input  logic          stat_rd_i,
  input  logic          lsi_en_i,
  output logic [DW-1:0] head_data_o,
  output logic          data_ready_o,
  output logic          overrun_o,
  output logic          par_err_o,
  output logic          frm_err_o,
  output logic          brk_err_o,
  output logic          fifo_err_o,
  output logic          irq_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int EW = DW + 3;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt, err_cnt;
  logic          ovr;

  logic          empty, full, do_pop, do_push, lost, new_tag, head_tag;
  logic [EW-1:0] head;

  assign empty    = (cnt == '0);
  assign full     = (cnt == FULLC);
  assign do_pop   = data_rd_i && !empty;
  assign do_push  = push_i && (!full || do_pop);
  assign lost     = push_i && !do_push;
  assign new_tag  = push_par_i | push_frm_i | push_brk_i;
  assign head     = empty ? '0 : mem[rptr];
  assign head_tag = |head[EW-1:DW];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= {push_brk_i, push_frm_i, push_par_i, push_data_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr    <= '0;
      rptr    <= '0;
      cnt     <= '0;
      err_cnt <= '0;
      ovr     <= 1'b0;
    end else begin
      if (do_push) wptr <= (wptr == LAST) ? '0 : wptr + 1'b1;
      if (do_pop)  rptr <= (rptr == LAST) ? '0 : rptr + 1'b1;
      cnt     <= cnt + CW'(do_push) - CW'(do_pop);
      err_cnt <= err_cnt + CW'(do_push && new_tag) - CW'(do_pop && head_tag);
      if (lost)           ovr <= 1'b1;
      else if (stat_rd_i) ovr <= 1'b0;
    end
  end

  assign head_data_o  = head[DW-1:0];
  assign par_err_o    = head[DW];
  assign frm_err_o    = head[DW+1];
  assign brk_err_o    = head[DW+2];
  assign data_ready_o = !empty;
  assign overrun_o    = ovr;
  assign fifo_err_o   = (err_cnt != '0);
  assign irq_o        = lsi_en_i && (fifo_err_o || ovr);
endmodule

// File: rtl/rx_err_fifo_chk.sv
module rx_err_fifo_chk #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       push_i,
  input logic                       data_rd_i,
  input logic                       stat_rd_i,
  input logic                       lsi_en_i,
  input logic [DW-1:0]              head_data_o,
  input logic                       data_ready_o,
  input logic                       overrun_o,
  input logic                       par_err_o,
  input logic                       frm_err_o,
  input logic                       brk_err_o,
  input logic                       fifo_err_o,
  input logic                       irq_o,
  input logic [$clog2(DEPTH):0]     cnt,
  input logic [$clog2(DEPTH):0]     err_cnt
);
  localparam int CW = $clog2(DEPTH) + 1;

  p_drop_on_full_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && cnt == CW'(DEPTH) && !data_rd_i) |=> (overrun_o && cnt == CW'(DEPTH)));

  p_store_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && cnt == CW'(DEPTH) && !data_rd_i) |=> ($stable(head_data_o) && $stable(err_cnt)));

  p_ready_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready_o) |-> $past(data_rd_i));

  p_tags_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready_o |-> !(par_err_o || frm_err_o || brk_err_o || fifo_err_o));

  p_errcnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_cnt <= cnt);

  p_irq_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (lsi_en_i && overrun_o) |-> irq_o);

  p_irq_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !lsi_en_i |-> !irq_o);

  p_ovr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !push_i) |=> !overrun_o);

  p_full_both_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && data_rd_i && cnt == CW'(DEPTH) && !overrun_o) |=> !overrun_o);

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_r10: assert (!overrun_o && !data_ready_o && !fifo_err_o && !irq_o);
    end
  end
endmodule

bind rx_err_fifo rx_err_fifo_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .push_i(push_i), .data_rd_i(data_rd_i),
  .stat_rd_i(stat_rd_i), .lsi_en_i(lsi_en_i), .head_data_o(head_data_o),
  .data_ready_o(data_ready_o), .overrun_o(overrun_o), .par_err_o(par_err_o),
  .frm_err_o(frm_err_o), .brk_err_o(brk_err_o), .fifo_err_o(fifo_err_o),
  .irq_o(irq_o), .cnt(cnt), .err_cnt(err_cnt)
);

// File: tb/rx_err_fifo_bench.sv
module rx_err_fifo_bench;
  localparam int DEPTH = 128;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       push_i = 0, push_par_i = 0, push_frm_i = 0, push_brk_i = 0;
  logic [7:0] push_data_i = 0;
  logic       data_rd_i = 0, stat_rd_i = 0, lsi_en_i = 0;
  logic [7:0] head_data_o;
  logic       data_ready_o, overrun_o, par_err_o, frm_err_o, brk_err_o, fifo_err_o, irq_o;

  rx_err_fifo u_rx_err_fifo (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .push_data_i(push_data_i),
    .push_par_i(push_par_i), .push_frm_i(push_frm_i), .push_brk_i(push_brk_i),
    .data_rd_i(data_rd_i), .stat_rd_i(stat_rd_i), .lsi_en_i(lsi_en_i),
    .head_data_o(head_data_o), .data_ready_o(data_ready_o), .overrun_o(overrun_o),
    .par_err_o(par_err_o), .frm_err_o(frm_err_o), .brk_err_o(brk_err_o),
    .fifo_err_o(fifo_err_o), .irq_o(irq_o)
  );

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [10:0] q [512];
  int qh = 0, qn = 0;
  bit  m_ovr = 0;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int tagged_left();
    int n = 0;
    for (int i = 0; i < qn; i++) if (|q[(qh + i) % 512][10:8]) n++;
    return n;
  endfunction

  task automatic check_all();
    logic [10:0] h;
    int t;
    h = (qn > 0) ? q[qh] : 11'd0;
    t = tagged_left();
    chk("R2 data_ready", int'(data_ready_o), int'(qn > 0));
    chk("R5 head byte", int'(head_data_o), int'(h[7:0]));
    chk("R6 parity tag", int'(par_err_o), int'(h[8]));
    chk("R6 framing tag", int'(frm_err_o), int'(h[9]));
    chk("R6 break tag", int'(brk_err_o), int'(h[10]));
    chk("R7 error summary", int'(fifo_err_o), int'(t > 0));
    chk("R3/R9 overrun", int'(overrun_o), int'(m_ovr));
    chk("R8 irq", int'(irq_o), int'(lsi_en_i && (t > 0 || m_ovr)));
  endtask

  task automatic step(input bit p, input logic [7:0] d, input logic [2:0] tg,
                      input bit rd, input bit sr);
    bit pop, acc;
    @(negedge clk);
    push_i = p; push_data_i = d; {push_brk_i, push_frm_i, push_par_i} = tg;
    data_rd_i = rd; stat_rd_i = sr;
    @(posedge clk);
    #2;
    push_i = 0; data_rd_i = 0; stat_rd_i = 0;
    pop = rd && qn > 0;
    acc = p && (qn < DEPTH || pop);
    if (pop) begin qh = (qh + 1) % 512; qn--; end
    if (acc) begin q[(qh + qn) % 512] = {tg, d}; qn++; end
    if (p && !acc) m_ovr = 1;
    else if (sr) m_ovr = 0;
    check_all();
  endtask

  function automatic logic [7:0] pat_d(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  function automatic logic [2:0] pat_t(input int i);
    return {i % 11 == 3, i % 7 == 2, i % 5 == 1};
  endfunction

  initial begin
    #(20 * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #35 rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 data_ready", int'(data_ready_o), 0);
    chk("R10 overrun", int'(overrun_o), 0);
    chk("R10 head byte", int'(head_data_o), 0);
    chk("R10 tags", int'({par_err_o, frm_err_o, brk_err_o, fifo_err_o, irq_o}), 0);
    // R5 read on empty queue is ignored
    step(0, 8'h00, 3'b000, 1, 0);
    // R1 fill 128 entries, interrupt disabled
    for (int i = 0; i < DEPTH; i++) step(1, pat_d(i), pat_t(i), 0, 0);
    chk("R1 no overrun after 128", int'(overrun_o), 0);
    lsi_en_i = 1; #1; check_all();
    // R3 overrun, R4 head untouched
    step(1, 8'hEE, 3'b111, 0, 0);
    chk("R4 head kept", int'(head_data_o), int'(pat_d(0)));
    // R3 set wins over simultaneous status read
    step(1, 8'hDD, 3'b000, 0, 1);
    chk("R3 set beats clear", int'(overrun_o), 1);
    // R9 status read clears
    step(0, 8'h00, 3'b000, 0, 1);
    chk("R9 cleared", int'(overrun_o), 0);
    // R11 push and pop together when full
    step(1, pat_d(DEPTH), pat_t(DEPTH), 1, 0);
    chk("R11 no overrun", int'(overrun_o), 0);
    chk("R11 head advanced", int'(head_data_o), int'(pat_d(1)));
    // R4 R5 R6 R7 drain in order
    for (int i = 0; i < DEPTH; i++) step(0, 8'h00, 3'b000, 1, 0);
    chk("R2 empty after drain", int'(data_ready_o), 0);
    // clean bytes with interrupt enabled: no summary, no irq (R7 R8)
    for (int i = 0; i < 20; i++) step(1, 8'(i), 3'b000, 0, 0);
    chk("R8 no irq on clean data", int'(irq_o), 0);
    // single tagged byte behind clean ones: summary on, head tags clear (R6 R7)
    step(1, 8'hA5, 3'b100, 0, 0);
    chk("R6 head tag is head's", int'(brk_err_o), 0);
    chk("R7 summary set", int'(fifo_err_o), 1);
    for (int i = 0; i < 22; i++) step(0, 8'h00, 3'b000, 1, 0);
    // R8 overrun alone with enable toggled
    for (int i = 0; i < DEPTH + 1; i++) step(1, 8'(i), 3'b000, 0, 0);
    lsi_en_i = 0; #1; check_all();
    lsi_en_i = 1; #1; check_all();
    step(0, 8'h00, 3'b000, 0, 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule